// File: doc/BRIEF.md
# Two-Lane Vector Permute Unit

This block rearranges and merges the two 64-bit lanes of a 128-bit vector register. It copies a whole register, replaces one lane with a 64-bit word from memory while keeping the other lane, picks one lane from each of two sources, interleaves the upper or the lower lanes of two sources, and packs the two lane sign bits into a small integer for a general-purpose register. The operand that represents the destination's old contents arrives on `src1`. Full-width data, whether it comes from a register or from a memory line, arrives on `src2`. A 64-bit memory word arrives on `mem_word`.

One operation is accepted per cycle when `op_valid` is high. Every result is registered and appears one clock edge after the operation is presented. A strobe marks the result for one cycle: `vec_we` for a vector result, `gpr_we` for a general-purpose result, or `align_fault` when an aligned-only full-width memory access uses an address that is not a multiple of 16 bytes. A fault replaces the vector write for that operation.

Top module: `lane_permute_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `vec_we`, `gpr_we` and `align_fault` are 0, and `vec_res` and `gpr_res` are 0.
- R2: Opcode 0 (aligned copy) produces `vec_res = src2`. If `mem_op` is 1 and `mem_addr[3:0]` is not zero, `align_fault` is 1 and `vec_we` is 0 instead.
- R3: Opcode 1 (unaligned copy) produces `vec_res = src2` with `vec_we = 1` and never raises `align_fault`, whatever the value of `mem_addr`.
- R4: Opcode 2 (scalar low move) writes `mem_word` into bits 63:0 when `mem_op` is 1, and `src2[63:0]` when `mem_op` is 0. Bits 127:64 are taken from `src1[127:64]`. No alignment check is made.
- R5: Opcode 3 (high insert) produces `{mem_word, src1[63:0]}`.
- R6: Opcode 4 (low insert) produces `{src1[127:64], mem_word}`.
- R7: Opcode 5 (shuffle) fills the low result lane from `src1`, using `imm[0]` to choose the lane, and fills the high result lane from `src2`, using `imm[1]` to choose the lane. In both fields 0 selects bits 63:0 and 1 selects bits 127:64.
- R8: Opcode 6 (high interleave) produces `{src2[127:64], src1[127:64]}`. The low lanes of both sources have no effect on the result.
- R9: Opcode 7 (low interleave) produces `{src2[63:0], src1[63:0]}`. The high lanes of both sources have no effect on the result.
- R10: Opcode 8 (sign mask) sets `gpr_we = 1` with `gpr_res[0] = src1[63]`, `gpr_res[1] = src1[127]` and `gpr_res[63:2] = 0`. It leaves `vec_we` at 0.
- R11: If `op_valid` is 0, or if the opcode is 9 to 15, none of the three strobes is raised.
- R12: Each result and strobe appears on the clock edge that samples the operation. A strobe lasts exactly one cycle unless another operation follows, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select (see requirements) |
| imm | input | 2 | Shuffle lane selects |
| mem_op | input | 1 | The operand comes from memory |
| mem_addr | input | 32 | Byte address of the memory operand |
| src1 | input | 128 | First source / old destination contents |
| src2 | input | 128 | Second source / full-width transfer data |
| mem_word | input | 64 | 64-bit memory word for lane inserts |
| vec_res | output | 128 | Registered vector result |
| vec_we | output | 1 | Vector result write strobe |
| gpr_res | output | 64 | Registered general-purpose result |
| gpr_we | output | 1 | General-purpose result write strobe |
| align_fault | output | 1 | Alignment protection fault |

## Verification
The hardest case to reach is a misaligned address on an aligned full-width copy when the operand really comes from memory. Random stimulus picks opcode 0 only about a tenth of the time and a memory operand half of the time. Random addresses fall on a 16-byte boundary only rarely, so the aligned side of the check would be hit too seldom. To cover it, the stimulus forces the low four address bits to zero in a quarter of the draws. Directed cases then place a fault directly beside legal writes, a misaligned unaligned copy and a misaligned scalar load. This shows that the fault blocks the write only for its own operation.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

    typedef enum logic [3:0] {
        OP_CPY_ALN = 4'd0,
        OP_CPY_UNA = 4'd1,
        OP_SCL_LO  = 4'd2,
        OP_INS_HI  = 4'd3,
        OP_INS_LO  = 4'd4,
        OP_SHUF    = 4'd5,
        OP_ILV_HI  = 4'd6,
        OP_ILV_LO  = 4'd7,
        OP_SGN_MSK = 4'd8
    } lpu_op_e;

    typedef enum logic [2:0] {
        SEL_S1_LO = 3'd0,
        SEL_S1_HI = 3'd1,
        SEL_S2_LO = 3'd2,
        SEL_S2_HI = 3'd3,
        SEL_MEM   = 3'd4
    } lane_src_e;

    typedef struct packed {
        logic      legal;
        logic      vec_wr;
        logic      gpr_wr;
        logic      chk_align;
        lane_src_e lane_hi;
        lane_src_e lane_lo;
    } lpu_ctrl_t;

    localparam int NUM_LANES = 2;

    function automatic lane_src_e pick_s1(input logic hi);
        return hi ? SEL_S1_HI : SEL_S1_LO;
    endfunction

    function automatic lane_src_e pick_s2(input logic hi);
        return hi ? SEL_S2_HI : SEL_S2_LO;
    endfunction

endpackage

// File: rtl/lpu_decode.sv
module lpu_decode
    import lpu_pkg::*;
(
    input  logic [3:0] op_code,
    input  logic [1:0] imm,
    input  logic       mem_op,
    output lpu_ctrl_t  ctrl
);
    always_comb begin
        ctrl = '{legal: 1'b0, vec_wr: 1'b0, gpr_wr: 1'b0, chk_align: 1'b0,
                 lane_hi: SEL_S1_HI, lane_lo: SEL_S1_LO};
        case (op_code)
            OP_CPY_ALN: begin
                ctrl.legal     = 1'b1;
                ctrl.vec_wr    = 1'b1;
                ctrl.chk_align = mem_op;
                ctrl.lane_hi   = SEL_S2_HI;
                ctrl.lane_lo   = SEL_S2_LO;
            end
            OP_CPY_UNA: begin
                ctrl.legal   = 1'b1;
                ctrl.vec_wr  = 1'b1;
                ctrl.lane_hi = SEL_S2_HI;
                ctrl.lane_lo = SEL_S2_LO;
            end
            OP_SCL_LO: begin
                ctrl.legal   = 1'b1;
                ctrl.vec_wr  = 1'b1;
                ctrl.lane_hi = SEL_S1_HI;
                ctrl.lane_lo = mem_op ? SEL_MEM : SEL_S2_LO;
            end
            OP_INS_HI: begin
                ctrl.legal   = 1'b1;
                ctrl.vec_wr  = 1'b1;
                ctrl.lane_hi = SEL_MEM;
                ctrl.lane_lo = SEL_S1_LO;
            end
            OP_INS_LO: begin
                ctrl.legal   = 1'b1;
                ctrl.vec_wr  = 1'b1;
                ctrl.lane_hi = SEL_S1_HI;
                ctrl.lane_lo = SEL_MEM;
            end
            OP_SHUF: begin
                ctrl.legal   = 1'b1;
                ctrl.vec_wr  = 1'b1;
                ctrl.lane_hi = pick_s2(imm[1]);
                ctrl.lane_lo = pick_s1(imm[0]);
            end
            OP_ILV_HI: begin
                ctrl.legal   = 1'b1;
                ctrl.vec_wr  = 1'b1;
                ctrl.lane_hi = SEL_S2_HI;
                ctrl.lane_lo = SEL_S1_HI;
            end
            OP_ILV_LO: begin
                ctrl.legal   = 1'b1;
                ctrl.vec_wr  = 1'b1;
                ctrl.lane_hi = SEL_S2_LO;
                ctrl.lane_lo = SEL_S1_LO;
            end
            OP_SGN_MSK: begin
                ctrl.legal  = 1'b1;
                ctrl.gpr_wr = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpu_lane_sel.sv
module lpu_lane_sel
    import lpu_pkg::*;
#(
    parameter int LANE_W = 64,
    localparam int VEC_W = NUM_LANES * LANE_W
) (
    input  logic [VEC_W-1:0]     src1,
    input  logic [VEC_W-1:0]     src2,
    input  logic [LANE_W-1:0]    mem_word,
    input  lpu_ctrl_t            ctrl,
    output logic [VEC_W-1:0]     vec_out,
    output logic [NUM_LANES-1:0] signs
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lane_src_e sel;
        assign sel = (g == 0) ? ctrl.lane_lo : ctrl.lane_hi;
        always_comb begin
            case (sel)
                SEL_S1_LO: vec_out[g*LANE_W +: LANE_W] = src1[0 +: LANE_W];
                SEL_S1_HI: vec_out[g*LANE_W +: LANE_W] = src1[LANE_W +: LANE_W];
                SEL_S2_LO: vec_out[g*LANE_W +: LANE_W] = src2[0 +: LANE_W];
                SEL_S2_HI: vec_out[g*LANE_W +: LANE_W] = src2[LANE_W +: LANE_W];
                default:   vec_out[g*LANE_W +: LANE_W] = mem_word;
            endcase
        end
        assign signs[g] = src1[g*LANE_W + LANE_W - 1];
    end
endmodule

// File: rtl/lpu_align_chk.sv
module lpu_align_chk #(
    parameter int ADDR_W      = 32,
    parameter int ALIGN_BYTES = 16,
    localparam int ALIGN_LSB  = $clog2(ALIGN_BYTES)
) (
    input  logic              chk,
    input  logic [ADDR_W-1:0] addr,
    output logic              misaligned
);
    assign misaligned = chk && (addr[ALIGN_LSB-1:0] != '0);
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import lpu_pkg::*;
#(
    parameter int LANE_W      = 64,
    parameter int ADDR_W      = 32,
    parameter int ALIGN_BYTES = 16,
    localparam int VEC_W      = NUM_LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [1:0]        imm,
    input  logic              mem_op,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [VEC_W-1:0]  src1,
    input  logic [VEC_W-1:0]  src2,
    input  logic [LANE_W-1:0] mem_word,
    output logic [VEC_W-1:0]  vec_res,
    output logic              vec_we,
    output logic [LANE_W-1:0] gpr_res,
    output logic              gpr_we,
    output logic              align_fault
);
    lpu_ctrl_t              ctrl;
    logic [VEC_W-1:0]       lanes;
    logic [NUM_LANES-1:0]   signs;
    logic                   misal;
    logic                   go;
    logic                   do_vec;
    logic                   do_gpr;

    lpu_decode u_decode (
        .op_code (op_code),
        .imm     (imm),
        .mem_op  (mem_op),
        .ctrl    (ctrl)
    );

    lpu_lane_sel #(.LANE_W(LANE_W)) u_lane_sel (
        .src1     (src1),
        .src2     (src2),
        .mem_word (mem_word),
        .ctrl     (ctrl),
        .vec_out  (lanes),
        .signs    (signs)
    );

    lpu_align_chk #(.ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN_BYTES)) u_align (
        .chk        (ctrl.chk_align),
        .addr       (mem_addr),
        .misaligned (misal)
    );

    assign go     = op_valid && ctrl.legal;
    assign do_vec = go && ctrl.vec_wr && !misal;
    assign do_gpr = go && ctrl.gpr_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_res     <= '0;
            gpr_res     <= '0;
            vec_we      <= 1'b0;
            gpr_we      <= 1'b0;
            align_fault <= 1'b0;
        end else begin
            vec_we      <= do_vec;
            gpr_we      <= do_gpr;
            align_fault <= go && misal;
            if (do_vec) vec_res <= lanes;
            if (do_gpr) gpr_res <= {{(LANE_W-NUM_LANES){1'b0}}, signs};
        end
    end

    // R12: at most one strobe per cycle; a fault never coexists with a write
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vec_we, gpr_we, align_fault}));

    // R3: unaligned copy never faults
    p_una_nofault_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CPY_UNA) |=> (!align_fault && vec_we));

    // R6: low insert keeps the high lane of the old destination
    p_lo_ins_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_INS_LO) |=>
            (vec_res[VEC_W-1:LANE_W] == $past(src1[VEC_W-1:LANE_W])));

    // R5: high insert keeps the low lane of the old destination
    p_hi_ins_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_INS_HI) |=>
            (vec_res[LANE_W-1:0] == $past(src1[LANE_W-1:0])));

    // R10: sign mask has zero upper bits
    p_sgn_upper_r10: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (gpr_res[LANE_W-1:NUM_LANES] == '0));

    // R11: nothing is written after an idle cycle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !(vec_we || gpr_we || align_fault));

    // R2: a misaligned aligned-only memory copy faults
    p_aln_fault_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CPY_ALN && mem_op && mem_addr[3:0] != 4'd0)
            |=> (align_fault && !vec_we));
endmodule

// File: tb/test_lane_permute_unit.sv
module test_lane_permute_unit;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         op_valid;
    logic [3:0]   op_code;
    logic [1:0]   imm;
    logic         mem_op;
    logic [31:0]  mem_addr;
    logic [127:0] src1, src2;
    logic [63:0]  mem_word;
    logic [127:0] vec_res;
    logic         vec_we;
    logic [63:0]  gpr_res;
    logic         gpr_we;
    logic         align_fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic         e_vwe, e_gwe, e_flt;
    logic [127:0] e_vec;
    logic [63:0]  e_gpr;
    string        e_tag;

    always #(CLK_P/2) clk = ~clk;

    lane_permute_unit i_lane_permute_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .imm(imm),
        .mem_op(mem_op), .mem_addr(mem_addr), .src1(src1), .src2(src2),
        .mem_word(mem_word), .vec_res(vec_res), .vec_we(vec_we),
        .gpr_res(gpr_res), .gpr_we(gpr_we), .align_fault(align_fault)
    );

    function automatic logic [127:0] model_vec(input logic [3:0] op, input logic [1:0] im,
            input logic mo, input logic [127:0] a, input logic [127:0] b, input logic [63:0] w);
        case (op)
            4'd0, 4'd1: return b;
            4'd2:       return {a[127:64], mo ? w : b[63:0]};
            4'd3:       return {w, a[63:0]};
            4'd4:       return {a[127:64], w};
            4'd5:       return {im[1] ? b[127:64] : b[63:0], im[0] ? a[127:64] : a[63:0]};
            4'd6:       return {b[127:64], a[127:64]};
            4'd7:       return {b[63:0], a[63:0]};
            default:    return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic v, input logic [3:0] op);
        if (!v || op > 4'd8) return "R11";
        case (op)
            4'd0: return "R2";  4'd1: return "R3";  4'd2: return "R4";
            4'd3: return "R5";  4'd4: return "R6";  4'd5: return "R7";
            4'd6: return "R8";  4'd7: return "R9";  default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_prev();
        chk(e_tag, "vec_we", {127'd0, vec_we}, {127'd0, e_vwe});
        chk(e_tag, "gpr_we", {127'd0, gpr_we}, {127'd0, e_gwe});
        chk(e_tag, "align_fault", {127'd0, align_fault}, {127'd0, e_flt});
        if (e_vwe) chk(e_tag, "vec_res", vec_res, e_vec);
        if (e_gwe) chk(e_tag, "gpr_res", {64'd0, gpr_res}, {64'd0, e_gpr});
    endtask

    task automatic step(input logic v, input logic [3:0] op, input logic [1:0] im,
            input logic mo, input logic [31:0] ad, input logic [127:0] a,
            input logic [127:0] b, input logic [63:0] w);
        logic legal;
        @(negedge clk);
        check_prev();
        op_valid = v; op_code = op; imm = im; mem_op = mo; mem_addr = ad;
        src1 = a; src2 = b; mem_word = w;
        legal  = v && (op <= 4'd8);
        e_flt  = legal && op == 4'd0 && mo && ad[3:0] != 4'd0;
        e_vwe  = legal && op <= 4'd7 && !e_flt;
        e_gwe  = legal && op == 4'd8;
        e_vec  = model_vec(op, im, mo, a, b, w);
        e_gpr  = {62'd0, a[127], a[63]};
        e_tag  = tag_of(v, op);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; op_valid = 0; op_code = 0; imm = 0; mem_op = 0; mem_addr = 0;
        src1 = 0; src2 = 0; mem_word = 0;
        e_vwe = 0; e_gwe = 0; e_flt = 0; e_vec = 0; e_gpr = 0; e_tag = "R1";
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset outputs", {vec_res[63:0], gpr_res}, 128'd0);
        chk("R1", "reset strobes", {125'd0, vec_we, gpr_we, align_fault}, 128'd0);
        rst = 1'b0;
        a = {64'h8000_0000_0000_0011, 64'h0000_0000_0000_0022};
        b = {64'hAAAA_0000_0000_0001, 64'h5555_0000_0000_0002};
        // R2: aligned copy, misaligned then aligned; R3 misaligned unaligned copy
        step(1, 4'd0, 2'b00, 1, 32'h0000_1008, a, b, 64'h1);
        step(1, 4'd0, 2'b00, 1, 32'h0000_1000, a, b, 64'h1);
        step(1, 4'd0, 2'b00, 0, 32'h0000_1003, a, b, 64'h1);
        step(1, 4'd1, 2'b00, 1, 32'h0000_100F, a, b, 64'h1);
        // R4: misaligned scalar load from memory, and register form
        step(1, 4'd2, 2'b00, 1, 32'h0000_0007, a, b, 64'hDEAD_BEEF_0BAD_F00D);
        step(1, 4'd2, 2'b00, 0, 32'h0000_0007, a, b, 64'hDEAD_BEEF_0BAD_F00D);
        // R5, R6 inserts
        step(1, 4'd3, 2'b00, 1, 32'h4, a, b, 64'h1234_5678_9ABC_DEF0);
        step(1, 4'd4, 2'b00, 1, 32'h4, a, b, 64'h0FED_CBA9_8765_4321);
        // R7: all four shuffle selects
        for (int k = 0; k < 4; k++) step(1, 4'd5, k[1:0], 0, 32'h0, a, b, 64'h0);
        // R8, R9 interleaves
        step(1, 4'd6, 2'b00, 0, 32'h0, a, b, 64'h0);
        step(1, 4'd7, 2'b00, 0, 32'h0, a, b, 64'h0);
        // R10: sign mask over all sign combinations
        for (int k = 0; k < 4; k++)
            step(1, 4'd8, 2'b00, 0, 32'h0, {k[1], 63'h1, k[0], 63'h2}, b, 64'h0);
        // R11: illegal opcode and idle
        step(1, 4'd9, 2'b00, 1, 32'h1, a, b, 64'h0);
        step(1, 4'd15, 2'b00, 1, 32'h1, a, b, 64'h0);
        step(0, 4'd0, 2'b00, 1, 32'h1, a, b, 64'h0);
        // R12: a lone write followed by idle gives a one-cycle strobe
        step(1, 4'd1, 2'b00, 0, 32'h0, a, b, 64'h0);
        step(0, 4'd1, 2'b00, 0, 32'h0, a, b, 64'h0);
        step(0, 4'd0, 2'b00, 0, 32'h0, a, b, 64'h0);
        // random stimulus
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ad;
            ad = $urandom();
            if ($urandom_range(0, 3) == 0) ad[3:0] = 4'd0;
            step($urandom_range(0, 9) != 0, 4'($urandom_range(0, 10)), 2'($urandom()),
                 1'($urandom()), ad, rnd128(), rnd128(), {$urandom(), $urandom()});
        end
        step(0, 4'd0, 2'b00, 0, 32'h0, 128'd0, 128'd0, 64'd0);
        @(negedge clk);
        check_prev();
        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule